// File: doc/BRIEF.md
# Triggered Capture Buffer

This block is an on-chip logic-analyser memory. On every clock where the capture enable is high and capture has not yet stopped, it writes one data word into a circular memory of 2^LGMEM words. A trigger input is looked at only on those same enabled clocks. Once a trigger has been seen and the memory has been filled at least once, the block stores the current sample and then stops. That stored sample is the trigger sample, or, for a trigger that came before the memory was full, the sample that completes the first fill. When capture stops, that sample is the newest word in memory.

Software uses a small bus slave with one address line, which shares the capture clock. Address 0 returns a status word. A write to address 0 with the top data bit clear resets all capture state. Address 1 is the readout port: each read after the stop returns the next word, starting with the oldest. The interrupt output is the stopped flag, with no mask.

Top module: `capture_buffer`

## Requirements
- R1: After `rst`, or after a bus write to address 0 whose data bit BUSW-1 is 0, the status word equals LGMEM<<8 (primed, triggered and stopped all clear), `stop_irq` is low, and the next capture goes to the first memory slot.
- R2: A sample is stored only on clocks where `cap_en` is high and capture has not stopped. Consecutive stored samples occupy consecutive circular slots.
- R3: `trig_in` counts only on clocks where `cap_en` is high and capture has not stopped. When it counts, the triggered flag is set. A trigger on a clock with `cap_en` low changes nothing.
- R4: Capture stops on the enabled clock where a trigger is present or pending and the memory is full, counting the sample being stored. That sample is stored and becomes the newest word, so a full sequence of 2^LGMEM reads ends with it.
- R5: Once stopped, later capture clocks and triggers change neither the memory nor the flags until a reset.
- R6: The status word read at address 0 has bit 0 = primed (the memory has been filled once), bit 1 = triggered, bit 2 = stopped, bits 12:8 = LGMEM, and all other bits 0.
- R7: While stopped, each read of address 1 returns the next word from oldest to newest. After 2^LGMEM reads it wraps back to the oldest.
- R8: A read of address 1 while not stopped returns 0 and does not advance the read position.
- R9: A write to address 0 with bit BUSW-1 set, and any write to address 1, has no effect on the status or on the readout.
- R10: Every clock with `bus_cyc` and `bus_stb` high is answered by `bus_ack` high on the next clock, with read data valid in that cycle. `bus_stall` is always low.
- R11: `stop_irq` is high exactly while the stopped flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by capture and bus |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Sample-valid strobe |
| trig_in | input | 1 | Trigger, looked at on enabled clocks |
| cap_data | input | BUSW | Word to record |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus request strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 1 | 0 = control/status, 1 = readout |
| bus_wdata | input | BUSW | Write data |
| bus_ack | output | 1 | Acknowledge, one clock after the strobe |
| bus_stall | output | 1 | Always low |
| bus_rdata | output | BUSW | Read data |
| stop_irq | output | 1 | High while capture is stopped |

## Verification
The embedded assertions check, on every cycle, several properties. A strobe is always acknowledged on the next clock. The stopped flag stays set until a reset. The write pointer is frozen while stopped. A stop only ever happens on a clock that had `cap_en` high. A control reset always clears the flags. Some behaviour can only be shown by the bench's scenarios, because it depends on data values and order. That covers which word comes out of each read, that the trigger sample is the newest word, and the wrap after a full readout. It also covers the case of a trigger arriving before the memory is full, which delays the stop to the first full memory.

// File: rtl/capture_buffer.sv
module capture_buffer #(
  parameter int LGMEM = 6,
  parameter int BUSW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            trig_in,
  input  logic [BUSW-1:0] cap_data,
  input  logic            bus_cyc,
  input  logic            bus_stb,
  input  logic            bus_we,
  input  logic            bus_addr,
  input  logic [BUSW-1:0] bus_wdata,
  output logic            bus_ack,
  output logic            bus_stall,
  output logic [BUSW-1:0] bus_rdata,
  output logic            stop_irq
);
  localparam int DEPTH = 1 << LGMEM;

  logic [BUSW-1:0]  mem [DEPTH];
  logic [LGMEM-1:0] wr_ptr, rd_off, rd_idx;
  logic             primed, triggered, stopped;

  logic req, clr, store, full_now, trig_now;
  logic [BUSW-1:0] status;

  assign req      = bus_cyc && bus_stb;
  assign clr      = rst || (req && bus_we && !bus_addr && !bus_wdata[BUSW-1]);
  assign store    = cap_en && !stopped;
  assign full_now = primed || (wr_ptr == {LGMEM{1'b1}});
  assign trig_now = triggered || trig_in;
  assign rd_idx   = wr_ptr + rd_off;
  assign status   = BUSW'({LGMEM[4:0], 5'b0, stopped, triggered, primed});

  assign bus_stall = 1'b0;
  assign stop_irq  = stopped;

  always_ff @(posedge clk)
    if (store) mem[wr_ptr] <= cap_data;

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr    <= '0;
      primed    <= 1'b0;
      triggered <= 1'b0;
      stopped   <= 1'b0;
    end else if (store) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (wr_ptr == {LGMEM{1'b1}}) primed <= 1'b1;
      if (trig_in) triggered <= 1'b1;
      if (trig_now && full_now) stopped <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr)
      rd_off <= '0;
    else if (req && !bus_we && bus_addr && stopped)
      rd_off <= rd_off + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_ack <= 1'b0;
    else     bus_ack <= req;
  end

  always_ff @(posedge clk) begin
    if (!bus_addr)    bus_rdata <= status;
    else if (stopped) bus_rdata <= mem[rd_idx];
    else              bus_rdata <= '0;
  end

  assert_ack_next_R10: assert property (@(posedge clk) disable iff (rst)
    req |=> bus_ack);

  assert_stop_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (stopped && !clr) |=> stopped);

  assert_frozen_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    (stopped && !clr) |=> $stable(wr_ptr));

  assert_stop_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_irq) |-> $past(cap_en));

  assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!stop_irq && !primed && !triggered));

  assert_trig_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(triggered) |-> $past(cap_en && trig_in));
endmodule

// File: tb/capture_buffer_test.sv
module capture_buffer_test;
  localparam int LG = 4;
  localparam int N  = 1 << LG;
  localparam int W  = 32;
  localparam logic [W-1:0] ST0 = W'(LG) << 8;

  localparam int NSC = 3;
  localparam int SC_PRE  [NSC] = '{20, 3, 15};
  localparam int SC_GAP  [NSC] = '{0, 1, 0};
  localparam int SC_BASE [NSC] = '{32'h100, 32'h5000, 32'hA0000};

  logic clk = 0, rst = 1;
  logic cap_en = 0, trig_in = 0;
  logic [W-1:0] cap_data = '0;
  logic bus_cyc = 0, bus_stb = 0, bus_we = 0, bus_addr = 0;
  logic [W-1:0] bus_wdata = '0;
  logic bus_ack, bus_stall, stop_irq;
  logic [W-1:0] bus_rdata;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  capture_buffer #(.LGMEM(LG), .BUSW(W)) uut (
    .clk(clk), .rst(rst), .cap_en(cap_en), .trig_in(trig_in), .cap_data(cap_data),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_stall(bus_stall),
    .bus_rdata(bus_rdata), .stop_irq(stop_irq));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample(input logic en, input logic tr, input logic [W-1:0] d);
    @(negedge clk);
    cap_en = en; trig_in = tr; cap_data = d;
    @(negedge clk);
    cap_en = 0; trig_in = 0;
  endtask

  task automatic bus_write(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check("R10 write ack", W'(bus_ack), 1);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic a, output logic [W-1:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    check("R10 read ack", W'(bus_ack), 1);
    d = bus_rdata;
    bus_cyc = 0; bus_stb = 0;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset ack low", W'(bus_ack), 0);
    check("R1 reset irq", W'(stop_irq), 0);
    check("R10 stall low", W'(bus_stall), 0);
    bus_read(0, r); check("R1 R6 reset status", r, ST0);

    for (int s = 0; s < NSC; s++) begin
      int stop_at, base;
      base = SC_BASE[s];
      stop_at = (SC_PRE[s] > N-1) ? SC_PRE[s] : N-1;
      bus_write(0, 32'h0);
      for (int i = 0; i < stop_at + 4; i++) begin
        if (SC_GAP[s] != 0) sample(0, 0, 32'hDEAD);
        sample(1, i == SC_PRE[s] || i > stop_at, W'(base + i));
      end
      check("R11 irq when stopped", W'(stop_irq), 1);
      bus_read(0, r); check("R4 R6 status after stop", r, ST0 | 7);
      for (int k = 0; k < N; k++) begin
        bus_read(1, r);
        check("R2 R4 R5 R7 readout", r, W'(base + stop_at - N + 1 + k));
      end
      bus_read(1, r); check("R7 wrap to oldest", r, W'(base + stop_at - N + 1));
    end

    bus_write(0, 32'h0);
    bus_read(0, r); check("R1 control reset status", r, ST0);
    check("R1 control reset irq", W'(stop_irq), 0);
    for (int i = 0; i < N; i++) sample(1, 0, W'(i));
    bus_read(0, r); check("R6 primed only", r, ST0 | 1);
    sample(0, 1, 32'h77);
    bus_read(0, r); check("R3 trigger without enable ignored", r, ST0 | 1);
    bus_read(1, r); check("R8 read before stop", r, 0);
    bus_write(0, 32'h8000_0000);
    bus_write(1, 32'h0);
    bus_read(0, r); check("R9 ignored writes", r, ST0 | 1);
    sample(1, 1, 32'h99);
    bus_read(0, r); check("R3 R4 trigger stops", r, ST0 | 7);
    bus_write(1, 32'h0);
    for (int k = 0; k < N - 1; k++) bus_read(1, r);
    check("R8 no advance before stop", r, W'(N - 1));
    bus_read(1, r); check("R4 trigger sample newest", r, 32'h99);
    bus_write(0, 32'h8000_0000);
    check("R9 irq unchanged", W'(stop_irq), 1);
    rst = 1; @(negedge clk); rst = 0;
    bus_read(0, r); check("R1 rst input", r, ST0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule